// File: doc/BRIEF.md
# Extended to Double Precision Format Converter

This block moves floating-point values between an 80-bit extended-precision word and a 64-bit double-precision word, in either direction. The extended word carries a 64-bit significand with an explicit integer bit in bits 63..0, a 15-bit exponent in bits 78..64, and the sign in bit 79. The double word uses the common layout: sign in bit 63, an 11-bit exponent in bits 62..52, and a 52-bit fraction in bits 51..0.

A request is a one-cycle pulse on `req_valid`. `req_dir` selects the direction: 0 narrows extended to double, and 1 widens double to extended. Both conversions are combinational and feed registered outputs. `out_valid` pulses one cycle after each request. Significand bits that do not fit are truncated, with no rounding. NaN and denormal inputs get no special treatment. In the narrowing direction the re-biased exponent magnitude is folded into 10 bits. Infinity is recognised only when narrowing, and zero is recognised only when widening.

Top module: `ext_dbl_conv`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, `out_valid`, `dbl_out` and `ext_out` are all zero.
- R2: `out_valid` is high in exactly those cycles that directly follow a cycle with `req_valid` high.
- R3: When narrowing (`req_dir`=0), for any input other than the infinity pattern of R5, `dbl_out[63]` equals `ext_in[79]` and `dbl_out[51:0]` equals `ext_in[62:11]`. Bits 10..0 of the significand are dropped.
- R4: When narrowing, apart from the R5 case, let U = `ext_in[78:64]` − 16383. Let M be |U| mod 1024. Then `dbl_out[62:52]` is 1023 + M when U > 0, and 1023 − M otherwise. For example, U = 1024 gives 1023 and U = −16383 gives 0.
- R5: When narrowing an input with `ext_in[78:64]` = 0x7FFF and `ext_in[63:0]` = 0x8000000000000000, `dbl_out` is a signed infinity: sign `ext_in[79]`, exponent 0x7FF, fraction zero.
- R6: When widening (`req_dir`=1) a double with `dbl_in[62:0]` nonzero, `ext_out[79]` equals `dbl_in[63]`. `ext_out[78:64]` equals `dbl_in[62:52]` + 15360. `ext_out[63]` is 1, `ext_out[62:11]` equals `dbl_in[51:0]`, and `ext_out[10:0]` is zero.
- R7: When widening a double with `dbl_in[62:0]` zero, `ext_out[78:0]` is zero and `ext_out[79]` equals `dbl_in[63]`, so negative zero keeps its sign.
- R8: A narrowing request leaves `ext_out` unchanged, and a widening request leaves `dbl_out` unchanged. In a cycle without a request, both outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Conversion request strobe |
| req_dir | input | 1 | 0 = extended to double, 1 = double to extended |
| ext_in | input | 80 | Extended-precision operand |
| dbl_in | input | 64 | Double-precision operand |
| out_valid | output | 1 | Result strobe, one cycle after a request |
| dbl_out | output | 64 | Registered double-precision result |
| ext_out | output | 80 | Registered extended-precision result |

## Verification
The only state is the two result registers and the strobe. A fault in any of them shows at the ports on the very next clock: either a result word that differs from the behavioural model, or an output that changes when it should hold. The model is compared on every cycle. Because of this, a wrongly loaded register or a stray load enable is caught within one cycle of the request that exposed it. The stimulus targets the exponent folding boundaries (U of 0, 1, 1023, 1024, −1023, −1024 and −16383), near misses of the infinity pattern, and both signs of zero.

// File: rtl/ext_dbl_pkg.sv
package ext_dbl_pkg;
  typedef enum logic {
    DIR_NARROW = 1'b0,
    DIR_WIDEN  = 1'b1
  } conv_dir_e;
endpackage

// File: rtl/ext_dbl_narrow.sv
module ext_dbl_narrow #(
  parameter int XEXP_W  = 15,
  parameter int XSIG_W  = 64,
  parameter int DEXP_W  = 11,
  parameter int DFRAC_W = 52,
  parameter int FOLD_W  = 10
) (
  input  logic [XEXP_W+XSIG_W:0]  wide_word,
  output logic [DEXP_W+DFRAC_W:0] narrow_word
);
  localparam int XW    = 1 + XEXP_W + XSIG_W;
  localparam int DW    = 1 + DEXP_W + DFRAC_W;
  localparam int UW    = XEXP_W + 2;
  localparam int XBIAS = (1 << (XEXP_W - 1)) - 1;
  localparam int DBIAS = (1 << (DEXP_W - 1)) - 1;
  localparam logic signed [UW-1:0]   XBIAS_S = UW'(XBIAS);
  localparam logic [DEXP_W-1:0]      DBIAS_V = DEXP_W'(DBIAS);
  localparam logic [XSIG_W-1:0]      INF_SIG = {1'b1, {(XSIG_W-1){1'b0}}};

  logic                  sgn;
  logic [XEXP_W-1:0]     xexp;
  logic [XSIG_W-1:0]     xsig;
  logic signed [UW-1:0]  unb;
  logic [UW-1:0]         unb_u;
  logic [UW-1:0]         mag;
  logic [DEXP_W-1:0]     folded;
  logic                  above;
  logic                  is_inf;
  logic [DEXP_W-1:0]     dexp;

  always_comb begin
    sgn    = wide_word[XW-1];
    xexp   = wide_word[XW-2 -: XEXP_W];
    xsig   = wide_word[XSIG_W-1:0];
    unb    = $signed({2'b00, xexp}) - XBIAS_S;
    unb_u  = unb;
    mag    = unb_u[UW-1] ? (~unb_u + 1'b1) : unb_u;
    folded = DEXP_W'(mag[FOLD_W-1:0]);
    above  = !unb_u[UW-1] && (unb_u != '0);
    dexp   = above ? (DBIAS_V + folded) : (DBIAS_V - folded);
    is_inf = (&xexp) && (xsig == INF_SIG);
    if (is_inf) begin
      narrow_word = {sgn, {DEXP_W{1'b1}}, {DFRAC_W{1'b0}}};
    end else begin
      narrow_word = {sgn, dexp, xsig[XSIG_W-2 -: DFRAC_W]};
    end
  end

  logic unused_ok;
  assign unused_ok = ^{DW[0], xsig[XSIG_W-DFRAC_W-2:0]};
endmodule

// File: rtl/ext_dbl_widen.sv
module ext_dbl_widen #(
  parameter int XEXP_W  = 15,
  parameter int XSIG_W  = 64,
  parameter int DEXP_W  = 11,
  parameter int DFRAC_W = 52
) (
  input  logic [DEXP_W+DFRAC_W:0] narrow_word,
  output logic [XEXP_W+XSIG_W:0]  wide_word
);
  localparam int DW     = 1 + DEXP_W + DFRAC_W;
  localparam int PAD_W  = XSIG_W - 1 - DFRAC_W;
  localparam int XBIAS  = (1 << (XEXP_W - 1)) - 1;
  localparam int DBIAS  = (1 << (DEXP_W - 1)) - 1;
  localparam logic [XEXP_W-1:0] REBIAS = XEXP_W'(XBIAS - DBIAS);

  logic               sgn;
  logic [DEXP_W-1:0]  dexp;
  logic [DFRAC_W-1:0] frac;
  logic               nonzero;

  always_comb begin
    sgn     = narrow_word[DW-1];
    dexp    = narrow_word[DW-2 -: DEXP_W];
    frac    = narrow_word[DFRAC_W-1:0];
    nonzero = |narrow_word[DW-2:0];
    if (nonzero) begin
      wide_word = {sgn, XEXP_W'(dexp) + REBIAS, 1'b1, frac, {PAD_W{1'b0}}};
    end else begin
      wide_word = {sgn, {(XEXP_W + XSIG_W){1'b0}}};
    end
  end
endmodule

// File: rtl/ext_dbl_reg.sv
module ext_dbl_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end
endmodule

// File: rtl/ext_dbl_conv.sv
module ext_dbl_conv #(
  parameter int XEXP_W  = 15,
  parameter int XSIG_W  = 64,
  parameter int DEXP_W  = 11,
  parameter int DFRAC_W = 52,
  parameter int FOLD_W  = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic                      req_dir,
  input  logic [XEXP_W+XSIG_W:0]    ext_in,
  input  logic [DEXP_W+DFRAC_W:0]   dbl_in,
  output logic                      out_valid,
  output logic [DEXP_W+DFRAC_W:0]   dbl_out,
  output logic [XEXP_W+XSIG_W:0]    ext_out
);
  import ext_dbl_pkg::*;

  localparam int XW = 1 + XEXP_W + XSIG_W;
  localparam int DW = 1 + DEXP_W + DFRAC_W;

  conv_dir_e      dir;
  logic [DW-1:0]  narrow_res;
  logic [XW-1:0]  widen_res;
  logic           load_narrow;
  logic           load_widen;

  assign dir         = conv_dir_e'(req_dir);
  assign load_narrow = req_valid && (dir == DIR_NARROW);
  assign load_widen  = req_valid && (dir == DIR_WIDEN);

  ext_dbl_narrow #(
    .XEXP_W(XEXP_W), .XSIG_W(XSIG_W), .DEXP_W(DEXP_W),
    .DFRAC_W(DFRAC_W), .FOLD_W(FOLD_W)
  ) u_narrow (
    .wide_word   (ext_in),
    .narrow_word (narrow_res)
  );

  ext_dbl_widen #(
    .XEXP_W(XEXP_W), .XSIG_W(XSIG_W), .DEXP_W(DEXP_W), .DFRAC_W(DFRAC_W)
  ) u_widen (
    .narrow_word (dbl_in),
    .wide_word   (widen_res)
  );

  ext_dbl_reg #(.W(DW)) u_dbl_q (
    .clk (clk), .rst (rst), .load (load_narrow), .d (narrow_res), .q (dbl_out)
  );

  ext_dbl_reg #(.W(XW)) u_ext_q (
    .clk (clk), .rst (rst), .load (load_widen), .d (widen_res), .q (ext_out)
  );

  ext_dbl_reg #(.W(1)) u_vld_q (
    .clk (clk), .rst (rst), .load (1'b1), .d (req_valid), .q (out_valid)
  );
endmodule

// File: rtl/ext_dbl_conv_chk.sv
module ext_dbl_conv_chk #(
  parameter int XEXP_W  = 15,
  parameter int XSIG_W  = 64,
  parameter int DEXP_W  = 11,
  parameter int DFRAC_W = 52
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic                    req_dir,
  input logic [XEXP_W+XSIG_W:0]  ext_in,
  input logic [DEXP_W+DFRAC_W:0] dbl_in,
  input logic                    out_valid,
  input logic [DEXP_W+DFRAC_W:0] dbl_out,
  input logic [XEXP_W+XSIG_W:0]  ext_out
);
  localparam int XW    = 1 + XEXP_W + XSIG_W;
  localparam int DW    = 1 + DEXP_W + DFRAC_W;
  localparam int PAD_W = XSIG_W - 1 - DFRAC_W;

  logic inf_in;
  logic dzero_in;
  assign inf_in   = (&ext_in[XW-2 -: XEXP_W]) &&
                    (ext_in[XSIG_W-1:0] == {1'b1, {(XSIG_W-1){1'b0}}});
  assign dzero_in = (dbl_in[DW-2:0] == '0);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);
  p_narrow_frac_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_dir && !inf_in) |=>
      (dbl_out[DFRAC_W-1:0] == $past(ext_in[XSIG_W-2 -: DFRAC_W])) &&
      (dbl_out[DW-1] == $past(ext_in[XW-1])));
  p_narrow_inf_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_dir && inf_in) |=>
      (dbl_out[DW-2:0] == {{DEXP_W{1'b1}}, {DFRAC_W{1'b0}}}) &&
      (dbl_out[DW-1] == $past(ext_in[XW-1])));
  p_widen_lead_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_dir && !dzero_in) |=>
      ext_out[XSIG_W-1] && (ext_out[PAD_W-1:0] == '0));
  p_widen_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_dir && dzero_in) |=>
      (ext_out[XW-2:0] == '0) && (ext_out[XW-1] == $past(dbl_in[DW-1])));
  p_narrow_holds_ext_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_dir) |=> $stable(ext_out));
  p_widen_holds_dbl_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_dir) |=> $stable(dbl_out));
  p_idle_holds_r8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(dbl_out) && $stable(ext_out)));
endmodule

bind ext_dbl_conv ext_dbl_conv_chk #(
  .XEXP_W(XEXP_W), .XSIG_W(XSIG_W), .DEXP_W(DEXP_W), .DFRAC_W(DFRAC_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_dir(req_dir),
  .ext_in(ext_in), .dbl_in(dbl_in), .out_valid(out_valid),
  .dbl_out(dbl_out), .ext_out(ext_out)
);

// File: tb/ext_dbl_conv_bench.sv
module ext_dbl_conv_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_dir = 1'b0;
  logic [79:0] ext_in = '0;
  logic [63:0] dbl_in = '0;
  logic        out_valid;
  logic [63:0] dbl_out;
  logic [79:0] ext_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  ext_dbl_conv u_ext_dbl_conv (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_dir(req_dir),
    .ext_in(ext_in), .dbl_in(dbl_in), .out_valid(out_valid),
    .dbl_out(dbl_out), .ext_out(ext_out)
  );

  function automatic logic [63:0] ref_narrow(logic [79:0] x);
    int f, e, m, r;
    logic [63:0] res;
    f = int'(x[78:64]);
    e = f - 16383;
    m = ((e < 0) ? -e : e) % 1024;
    r = (e > 0) ? 1023 + m : 1023 - m;
    if (f == 32767 && x[63:0] == 64'h8000_0000_0000_0000)
      res = {x[79], 11'h7FF, 52'h0};
    else
      res = {x[79], r[10:0], x[62:11]};
    return res;
  endfunction

  function automatic logic [79:0] ref_widen(logic [63:0] d);
    int e;
    logic [79:0] res;
    e = int'(d[62:52]) + 15360;
    if (d[62:0] == 63'h0) res = {d[63], 79'h0};
    else                  res = {d[63], e[14:0], 1'b1, d[51:0], 11'h0};
    return res;
  endfunction

  // behavioural reference, one entry of state per clock
  logic        m_valid;
  logic [63:0] m_dbl;
  logic [79:0] m_ext;
  int          m_kind;   // 0 idle, 1 narrow, 2 widen
  bit          m_inf;
  bit          m_zero;

  always @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0; m_dbl <= '0; m_ext <= '0; m_kind <= 0;
      m_inf <= 1'b0; m_zero <= 1'b0;
    end else begin
      m_valid <= req_valid;
      if (req_valid && !req_dir) begin
        m_dbl  <= ref_narrow(ext_in);
        m_kind <= 1;
        m_inf  <= (ext_in[78:64] == 15'h7FFF) &&
                  (ext_in[63:0] == 64'h8000_0000_0000_0000);
      end else if (req_valid && req_dir) begin
        m_ext  <= ref_widen(dbl_in);
        m_kind <= 2;
        m_zero <= (dbl_in[62:0] == 63'h0);
      end else begin
        m_kind <= 0;
      end
    end
  end

  task automatic chk(string tag, logic [79:0] act, logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 out_valid", 80'(out_valid), 80'(m_valid));
    if (m_kind == 1 && m_inf) begin
      chk("R5 infinity", 80'(dbl_out), 80'(m_dbl));
    end else if (m_kind == 1) begin
      chk("R3 sign", 80'(dbl_out[63]), 80'(m_dbl[63]));
      chk("R3 fraction", 80'(dbl_out[51:0]), 80'(m_dbl[51:0]));
      chk("R4 exponent", 80'(dbl_out[62:52]), 80'(m_dbl[62:52]));
    end else begin
      chk("R8 dbl_out hold", 80'(dbl_out), 80'(m_dbl));
    end
    if (m_kind == 2 && m_zero)      chk("R7 zero", ext_out, m_ext);
    else if (m_kind == 2)           chk("R6 widen", ext_out, m_ext);
    else                            chk("R8 ext_out hold", ext_out, m_ext);
  endtask

  task automatic step(bit v, bit dir, logic [79:0] x, logic [63:0] d);
    @(negedge clk);
    compare_all();
    req_valid = v; req_dir = dir; ext_in = x; dbl_in = d;
  endtask

  function automatic logic [79:0] xw(bit s, int fld, logic [63:0] sig);
    logic [14:0] f;
    f = fld[14:0];
    return {s, f, sig};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset valid", 80'(out_valid), 80'h0);
    chk("R1 reset dbl", 80'(dbl_out), 80'h0);
    chk("R1 reset ext", ext_out, 80'h0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 after release", {79'h0, out_valid} | 80'(dbl_out) | ext_out, 80'h0);
    // infinity and near misses (R5, R4)
    step(1, 0, xw(0, 32767, 64'h8000_0000_0000_0000), 64'h0);
    step(1, 0, xw(1, 32767, 64'h8000_0000_0000_0000), 64'h0);
    step(1, 0, xw(0, 32767, 64'hC000_0000_0000_0000), 64'h0);
    step(1, 0, xw(0, 32767, 64'h8000_0000_0000_0800), 64'h0);
    step(1, 0, xw(0, 32766, 64'h8000_0000_0000_0000), 64'h0);
    // exponent folding boundaries (R4)
    step(1, 0, xw(0, 16383, 64'hFFFF_FFFF_FFFF_FFFF), 64'h0);
    step(1, 0, xw(1, 16384, 64'h8123_4567_89AB_CDEF), 64'h0);
    step(1, 0, xw(0, 16383 + 1023, 64'h8000_0000_0000_0000), 64'h0);
    step(1, 0, xw(0, 16383 + 1024, 64'h8000_0000_0000_0000), 64'h0);
    step(1, 0, xw(0, 16383 - 1023, 64'h8000_0000_0000_0000), 64'h0);
    step(1, 0, xw(0, 16383 - 1024, 64'h8000_0000_0000_0000), 64'h0);
    step(1, 0, xw(1, 0, 64'h0), 64'h0);
    step(0, 0, '0, '0);
    // widening (R6, R7)
    step(1, 1, '0, 64'h3FF0_0000_0000_0000);
    step(1, 1, '0, 64'h0000_0000_0000_0000);
    step(1, 1, '0, 64'h8000_0000_0000_0000);
    step(1, 1, '0, 64'hFFFF_FFFF_FFFF_FFFF);
    step(1, 1, '0, 64'h0000_0000_0000_0001);
    step(0, 1, '1, '1);
    step(0, 0, '1, '1);
    // mixed traffic, including the hold behaviour of R8
    for (int i = 0; i < 3000; i++) begin
      logic [79:0] x;
      logic [63:0] d;
      int sel;
      sel = int'($urandom_range(0, 9));
      x = {$urandom(), $urandom(), 16'($urandom())};
      d = {$urandom(), $urandom()};
      if (sel < 4) x[78:64] = 15'(16383 - 2100 + int'($urandom_range(0, 4200)));
      if (sel == 5) x = {x[79], 15'h7FFF, 64'h8000_0000_0000_0000};
      if (sel == 6) d = {d[63], 63'h0};
      step(($urandom_range(0, 3) != 0), $urandom_range(0, 1) == 1, x, d);
    end
    step(0, 0, '0, '0);
    step(0, 0, '0, '0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule